// File: doc/BRIEF.md
# Self-Recovering One-Hot Sequencer

This block is a nine-state controller that keeps its state in a one-hot register and steps through its states in a fixed ring. While the advance input is high it moves from each state to the next, and after the last state it returns to the first. While advance is low it holds its state.

If the register ever holds a value with no bit set or with more than one bit set, for example after a disturbance flips a flip-flop, the block raises a combinational illegal flag. On the next clock edge it reloads the initial state. The detection is ordinary decode logic on the register bits, not a default branch of a case statement, so synthesis cannot prune it as unreachable. A registered recovery pulse marks the cycle that follows a recovery.

A test-only injection port loads any chosen value into the state register on one edge. A bench uses it to reproduce single-bit, multi-bit and all-zero corruptions.

Top module: `ohg_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the state becomes 9'h001 (bit 0 set) and recovered becomes 0. This applies whatever advance, inj_en and the current state are.
- R2: With a legal state, inj_en low and advance high, a rising edge moves the single set bit from position i to position i+1.
- R3: With a legal state of 9'h100 (bit 8), inj_en low and advance high, a rising edge gives 9'h001.
- R4: With a legal state, inj_en low and advance low, the state is unchanged across the edge.
- R5: illegal is 1 exactly when the state has zero bits set or two or more bits set, and 0 when exactly one bit is set. It follows the state within the same cycle.
- R6: When illegal is 1 and inj_en is low at a rising edge, the state becomes 9'h001 whatever advance is.
- R7: recovered is 1 for exactly the one cycle that follows an edge on which R6 applied, and 0 in every other cycle.
- R8: When inj_en is high at a rising edge (rst_n high), the state loads inj_val. This takes priority over recovery and over advance, and recovered is then 0 in the next cycle.
- R9: After any single extra bit is set on top of a legal state, the machine is back in 9'h001 after one edge. It does not lock up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| advance | input | 1 | Step to the next state when high |
| inj_en | input | 1 | Test hook: load inj_val into the state register on this edge |
| inj_val | input | 9 | Test hook: value to load |
| state | output | 9 | One-hot state vector, bit i = state i |
| illegal | output | 1 | Combinational: state is not exactly one-hot |
| recovered | output | 1 | High for one cycle after an illegal-state recovery |

## Verification
The bench walks the whole ring with advance high and low, including the wrap from the last state to the first. A design with a wrong rotate would skip a state or lose its bit at the wrap.

It then injects the all-zero value, the all-ones value, two-bit values, and every single extra bit on top of state 0. A detector that only looks for two or more bits set would leave the all-zero case stuck forever. A recovery that relies on an unreachable branch would stay in the corrupted value.

It also checks that advance is ignored during recovery, that a legal injection on an illegal cycle wins and raises no pulse, and that reset overrides both injection and recovery. A pulse that lasts longer than one cycle, or one that fires after an injection, is reported.

// File: rtl/ohg_pkg.sv
// Package ohg_pkg: shared types for the self-recovering one-hot sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ohg_pkg;
    // Kind of update applied to the state register on the next edge.
    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_STEP    = 2'd1,
        UPD_RECOVER = 2'd2,
        UPD_LOAD    = 2'd3
    } upd_e;
endpackage

// File: rtl/ohg_legal.sv
// Module ohg_legal: flags a vector that is not exactly one-hot.
// Detects both the all-zero value and any value with two or more bits set.
// Assumes: N >= 2. clk/rst_n are used only by the assertion.
module ohg_legal #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] vec,
    output logic         illegal
);
    logic any_set;
    logic multi_set;

    // Scan bits: note any bit seen, and any bit seen after another one.
    always_comb begin
        any_set   = 1'b0;
        multi_set = 1'b0;
        for (int i = 0; i < N; i++) begin
            multi_set = multi_set | (any_set & vec[i]);
            any_set   = any_set | vec[i];
        end
    end

    // Illegal when nothing is set or more than one bit is set.
    assign illegal = ~any_set | multi_set;

    assert_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal == ($countones(vec) != 1))
        else $error("R5 illegal flag disagrees with bit count");
endmodule

// File: rtl/ohg_next.sv
// Module ohg_next: next-state selection for the one-hot ring.
// Priority: injection, then recovery, then step, then hold.
// Assumes: cur is the registered state; illegal comes from ohg_legal.
module ohg_next
    import ohg_pkg::*;
#(
    parameter int N = 9
) (
    input  logic [N-1:0] cur,
    input  logic         illegal,
    input  logic         advance,
    input  logic         inj_en,
    input  logic [N-1:0] inj_val,
    output logic [N-1:0] nxt,
    output upd_e         upd
);
    localparam logic [N-1:0] INIT = {{(N-1){1'b0}}, 1'b1};

    // Choose the update kind and the value to load.
    always_comb begin
        if (inj_en) begin
            upd = UPD_LOAD;
            nxt = inj_val;
        end else if (illegal) begin
            upd = UPD_RECOVER;
            nxt = INIT;
        end else if (advance) begin
            upd = UPD_STEP;
            nxt = {cur[N-2:0], cur[N-1]};
        end else begin
            upd = UPD_HOLD;
            nxt = cur;
        end
    end
endmodule

// File: rtl/ohg_reg.sv
// Module ohg_reg: state register and registered recovery pulse.
// Assumes: synchronous active-low reset; upd comes from ohg_next.
module ohg_reg
    import ohg_pkg::*;
#(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] nxt,
    input  upd_e         upd,
    output logic [N-1:0] state,
    output logic         recovered
);
    localparam logic [N-1:0] INIT = {{(N-1){1'b0}}, 1'b1};

    // Load the next state and note when this edge was a recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= INIT;
            recovered <= 1'b0;
        end else begin
            state     <= nxt;
            recovered <= (upd == UPD_RECOVER);
        end
    end

    assert_recover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == UPD_RECOVER) |=> (state == INIT) && recovered)
        else $error("R6 recovery did not land in the initial state");

    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        recovered |=> !recovered)
        else $error("R7 recovery pulse longer than one cycle");
endmodule

// File: rtl/ohg_top.sv
// Module ohg_top: nine-state one-hot ring sequencer with explicit recovery
// from illegal register values. The inj_* port is a test hook only.
// Assumes: N_STATES >= 2; inj_en is tied low in functional use.
module ohg_top
    import ohg_pkg::*;
#(
    parameter int N_STATES = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  logic                inj_en,
    input  logic [N_STATES-1:0] inj_val,
    output logic [N_STATES-1:0] state,
    output logic                illegal,
    output logic                recovered
);
    logic [N_STATES-1:0] nxt;
    upd_e                upd;

    ohg_legal #(.N(N_STATES)) u_legal (
        .clk     (clk),
        .rst_n   (rst_n),
        .vec     (state),
        .illegal (illegal)
    );

    ohg_next #(.N(N_STATES)) u_next (
        .cur     (state),
        .illegal (illegal),
        .advance (advance),
        .inj_en  (inj_en),
        .inj_val (inj_val),
        .nxt     (nxt),
        .upd     (upd)
    );

    ohg_reg #(.N(N_STATES)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt       (nxt),
        .upd       (upd),
        .state     (state),
        .recovered (recovered)
    );

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal && !inj_en && advance) |=>
            state == $past({state[N_STATES-2:0], state[N_STATES-1]}))
        else $error("R2 step did not rotate the state");

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal && !inj_en && !advance) |=> $stable(state))
        else $error("R4 state changed without advance");

    assert_inject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inj_en |=> (state == $past(inj_val)) && !recovered)
        else $error("R8 injected value not loaded");
endmodule

// File: tb/tb_ohg_top.sv
// Bench for ohg_top: a vector table walked by one loop, then directed tests.
module tb_ohg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       advance = 1'b0;
    logic       inj_en = 1'b0;
    logic [8:0] inj_val = '0;
    logic [8:0] state;
    logic       illegal;
    logic       recovered;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ohg_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .inj_en    (inj_en),
        .inj_val   (inj_val),
        .state     (state),
        .illegal   (illegal),
        .recovered (recovered)
    );

    typedef struct packed {
        logic       adv;
        logic       ien;
        logic [8:0] ival;
        logic [8:0] est;
        logic       eill;
        logic       erec;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 9'h000, 9'h002, 1'b0, 1'b0, 4'd2}, // R2
        '{1'b0, 1'b0, 9'h000, 9'h002, 1'b0, 1'b0, 4'd4}, // R4
        '{1'b1, 1'b0, 9'h000, 9'h004, 1'b0, 1'b0, 4'd2},
        '{1'b1, 1'b0, 9'h000, 9'h008, 1'b0, 1'b0, 4'd2},
        '{1'b1, 1'b0, 9'h000, 9'h010, 1'b0, 1'b0, 4'd2},
        '{1'b1, 1'b0, 9'h000, 9'h020, 1'b0, 1'b0, 4'd2},
        '{1'b1, 1'b0, 9'h000, 9'h040, 1'b0, 1'b0, 4'd2},
        '{1'b1, 1'b0, 9'h000, 9'h080, 1'b0, 1'b0, 4'd2},
        '{1'b1, 1'b0, 9'h000, 9'h100, 1'b0, 1'b0, 4'd2},
        '{1'b1, 1'b0, 9'h000, 9'h001, 1'b0, 1'b0, 4'd3}, // R3 wrap
        '{1'b0, 1'b1, 9'h003, 9'h003, 1'b1, 1'b0, 4'd8}, // R8, R5 two bits
        '{1'b1, 1'b0, 9'h000, 9'h001, 1'b0, 1'b1, 4'd6}, // R6, R7
        '{1'b0, 1'b0, 9'h000, 9'h001, 1'b0, 1'b0, 4'd7}, // R7 pulse ends
        '{1'b0, 1'b1, 9'h000, 9'h000, 1'b1, 1'b0, 4'd5}, // R5 all zero
        '{1'b0, 1'b0, 9'h000, 9'h001, 1'b0, 1'b1, 4'd6},
        '{1'b0, 1'b1, 9'h1FF, 9'h1FF, 1'b1, 1'b0, 4'd5}, // R5 all ones
        '{1'b1, 1'b0, 9'h000, 9'h001, 1'b0, 1'b1, 4'd6}, // R6 ignores advance
        '{1'b1, 1'b0, 9'h000, 9'h002, 1'b0, 1'b0, 4'd2},
        '{1'b0, 1'b1, 9'h012, 9'h012, 1'b1, 1'b0, 4'd9}, // R9 flipped bit
        '{1'b1, 1'b1, 9'h040, 9'h040, 1'b0, 1'b0, 4'd8}, // R8 beats recovery
        '{1'b1, 1'b0, 9'h000, 9'h080, 1'b0, 1'b0, 4'd2}
    };

    task automatic chk(input logic [8:0] est, input logic eill,
                       input logic erec, input int rq);
        checks++;
        if (state !== est || illegal !== eill || recovered !== erec) begin
            errors++;
            $display("FAIL R%0d: state=%h illegal=%b recovered=%b expected state=%h illegal=%b recovered=%b",
                     rq, state, illegal, recovered, est, eill, erec);
        end
    endtask

    // Apply inputs at a falling edge, let one rising edge pass, sample at the next fall.
    task automatic step(input logic adv, input logic ien, input logic [8:0] ival);
        advance = adv;
        inj_en  = ien;
        inj_val = ival;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 1'b1, 9'h1FF);           // reset held, inputs active
        rst_n = 1'b1;
        chk(9'h001, 1'b0, 1'b0, 1);         // R1 reset state

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].adv, TBL[i].ien, TBL[i].ival);
            chk(TBL[i].est, TBL[i].eill, TBL[i].erec, int'(TBL[i].req));
        end

        // R9: every single extra bit on top of state 0 recovers in one edge.
        step(1'b0, 1'b1, 9'h001);
        for (int b = 1; b < 9; b++) begin
            step(1'b0, 1'b1, 9'h001 | (9'h001 << b));
            chk(9'h001 | (9'h001 << b), 1'b1, 1'b0, 9);
            step(1'b1, 1'b0, 9'h000);
            chk(9'h001, 1'b0, 1'b1, 9);
        end

        // R1: reset beats recovery while an illegal value is held.
        step(1'b0, 1'b1, 9'h003);
        rst_n = 1'b0;
        step(1'b1, 1'b0, 9'h000);
        chk(9'h001, 1'b0, 1'b0, 1);
        // R1: reset beats injection and advance.
        step(1'b1, 1'b1, 9'h0F0);
        chk(9'h001, 1'b0, 1'b0, 1);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 9'h000);
        chk(9'h002, 1'b0, 1'b0, 2);

        // R3/R4: hold at the last state, then wrap.
        step(1'b0, 1'b1, 9'h100);
        step(1'b0, 1'b0, 9'h000);
        chk(9'h100, 1'b0, 1'b0, 4);
        step(1'b1, 1'b0, 9'h000);
        chk(9'h001, 1'b0, 1'b0, 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule